// File: doc/BRIEF.md
# Branch Target Line Cache

This block is a small, fully associative cache that holds instruction bytes rather than addresses. The fetch path consults it only when a branch has been predicted taken. It presents the computed target address together with a strobe. If a valid entry carries that exact address, the block returns the 16-byte line stored for it in the same cycle. The instruction buffer can then start on the target without waiting one clock for the main instruction cache. On a miss, fetch falls back to the main cache, and the line that comes back is written in through the fill port together with its target address.

Replacement is handled inside the block. A fill whose address is already present rewrites that entry in place. Otherwise the fill takes the lowest-numbered empty entry. When no entry is empty, a round-robin pointer chooses the victim. A synchronous flush empties the whole cache. It is meant for use after the instruction stream has been modified.

Top module: `tgt_line_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: While `look_en` is low, `look_hit` is 0 and `look_line` is all zeros, whatever the address is.
- R3: With `look_en` high, `look_hit` is 1 in the same cycle exactly when a valid entry's tag equals all 32 bits of `look_addr`. `look_line` then carries that entry's 128-bit line, with byte i in bits [8i+7:8i]. On a miss `look_line` is all zeros.
- R4: A fill is not visible to a lookup in the same cycle. It is visible to lookups from the next cycle onward.
- R5: When no valid entry matches the fill address, the fill takes the lowest-numbered invalid entry. Up to 16 distinct lines can be resident at once.
- R6: A fill whose address matches a valid entry rewrites that entry's line in place. It never creates a second entry for the same address.
- R7: When all 16 entries are valid and the fill address matches none of them, the fill replaces the entry under a round-robin pointer. The pointer then advances by one, wrapping from 15 to 0. The pointer starts at 0 after reset and after a flush, and no other fill moves it.
- R8: A flush makes every entry invalid from the next cycle. A fill in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| look_en | input | 1 | Predicted-taken strobe qualifying the lookup |
| look_addr | input | 32 | Computed branch target address |
| look_hit | output | 1 | Lookup hit, same cycle |
| look_line | output | 128 | Instruction bytes at the target on a hit, else zero |
| fill_en | input | 1 | Write a line into the cache |
| fill_addr | input | 32 | Target address of the line being filled |
| fill_line | input | 128 | Line fetched from the main instruction cache |

## Verification
The hardest situation to reach is one in which a rewrite in place and a round-robin eviction give different results. The ports show this only in which address disappears later. To reach it, the bench fills 15 entries and then refills the first address with new data. It then fills two more addresses. If the rewrite had allocated a duplicate, the second of those fills would evict a different address from the one a correct design evicts. A scoreboard applies R5 to R7 to every fill. After each fill the bench sweeps every address it has used, so each hit, miss and line value is checked.

// File: rtl/tgt_line_cache.sv
module tgt_line_cache #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    look_en,
  input  logic [ADDR_W-1:0]       look_addr,
  output logic                    look_hit,
  output logic [LINE_BYTES*8-1:0] look_line,
  input  logic                    fill_en,
  input  logic [ADDR_W-1:0]       fill_addr,
  input  logic [LINE_BYTES*8-1:0] fill_line
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ADDR_W-1:0]  tag  [ENTRIES];
  logic [LINE_W-1:0]  data [ENTRIES];
  logic [IDX_W-1:0]   rr, hit_idx, same_idx, free_idx, victim;
  logic [ENTRIES-1:0] hit_vec, same_vec;
  logic               any_free, any_same, write, evict;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e]  = vld[e] && (tag[e] == look_addr);
    assign same_vec[e] = vld[e] && (tag[e] == fill_addr);
  end

  always_comb begin
    hit_idx  = '0;
    same_idx = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e])  hit_idx  = IDX_W'(e);
      if (same_vec[e]) same_idx = IDX_W'(e);
      if (!vld[e]) begin
        free_idx = IDX_W'(e);
        any_free = 1'b1;
      end
    end
  end

  assign any_same  = |same_vec;
  assign victim    = any_same ? same_idx : (any_free ? free_idx : rr);
  assign write     = fill_en && !flush;
  assign evict     = write && !any_same && !any_free;
  assign look_hit  = look_en && (|hit_vec);
  assign look_line = look_hit ? data[hit_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld <= '0;
      rr  <= '0;
    end else if (write) begin
      vld[victim] <= 1'b1;
      if (evict) rr <= (rr == LAST) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && write) begin
      tag[victim]  <= fill_addr;
      data[victim] <= fill_line;
    end
  end

  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !look_en |-> (!look_hit && look_line == '0));

  assert_fill_seen_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fill_en) && !$past(flush) && look_en
     && look_addr == $past(fill_addr)) |-> look_hit);

  assert_no_duplicate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_pointer_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush) && rr != $past(rr))
      |-> (rr == (($past(rr) == LAST) ? '0 : $past(rr) + 1'b1)));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !look_hit);
endmodule

// File: tb/tgt_line_cache_tb.sv
module tgt_line_cache_tb;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n, flush, look_en, look_hit, fill_en;
  logic [31:0]  look_addr, fill_addr;
  logic [127:0] look_line, fill_line;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit          m_vld [N];
  logic [31:0] m_tag [N];
  int          m_gen [N];
  int          m_rr;

  always #5 clk = ~clk;

  tgt_line_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_en(look_en), .look_addr(look_addr), .look_hit(look_hit), .look_line(look_line),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_line(fill_line)
  );

  function automatic logic [127:0] mk_line(input logic [31:0] a, input int g);
    logic [127:0] l;
    for (int i = 0; i < 16; i++)
      l[i*8 +: 8] = a[7:0] ^ a[23:16] ^ 8'(i * 29) ^ 8'(g * 7 + 1);
    return l;
  endfunction

  function automatic logic [31:0] addr_of(input int k);
    return 32'h4000_0000 + 32'(k) * 32'h00A1_3374;
  endfunction

  function automatic void m_clear();
    for (int e = 0; e < N; e++) m_vld[e] = 1'b0;
    m_rr = 0;
  endfunction

  function automatic void m_fill(input logic [31:0] a, input int g);
    int slot = -1;
    for (int e = 0; e < N; e++) if (slot < 0 && m_vld[e] && m_tag[e] == a) slot = e;
    if (slot < 0) for (int e = 0; e < N; e++) if (slot < 0 && !m_vld[e]) slot = e;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_vld[slot] = 1'b1;
    m_tag[slot] = a;
    m_gen[slot] = g;
  endfunction

  task automatic check(input string req, input bit act_hit, input logic [127:0] act_line,
                       input bit exp_hit, input logic [127:0] exp_line, input logic [31:0] a);
    checks++;
    if (act_hit !== exp_hit || act_line !== exp_line) begin
      failures++;
      $display("FAIL %s addr=%h hit=%b exp_hit=%b line=%h exp_line=%h",
               req, a, act_hit, exp_hit, act_line, exp_line);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a);
    bit eh = 1'b0;
    logic [127:0] el = '0;
    for (int e = 0; e < N; e++)
      if (m_vld[e] && m_tag[e] == a) begin
        eh = 1'b1;
        el = mk_line(a, m_gen[e]);
      end
    @(negedge clk);
    look_en = 1'b1;
    look_addr = a;
    #1 check(req, look_hit, look_line, eh, el, a);
    look_en = 1'b0;
  endtask

  task automatic fill(input logic [31:0] a, input int g, input bit fl);
    @(negedge clk);
    fill_en = 1'b1; fill_addr = a; fill_line = mk_line(a, g); flush = fl;
    @(posedge clk);
    if (fl) m_clear(); else m_fill(a, g);
    #1 fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic sweep(input string req, input int upto);
    for (int k = 0; k <= upto; k++) look(req, addr_of(k));
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; look_en = 1'b0; fill_en = 1'b0;
    look_addr = '0; fill_addr = '0; fill_line = '0;
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    sweep("R1 reset", 4);

    // R4: same-cycle fill is invisible, then visible
    @(negedge clk);
    fill_en = 1'b1; fill_addr = addr_of(0); fill_line = mk_line(addr_of(0), 0);
    look_en = 1'b1; look_addr = addr_of(0);
    #1 check("R4 same cycle", look_hit, look_line, 1'b0, '0, addr_of(0));
    @(posedge clk);
    m_fill(addr_of(0), 0);
    #1 fill_en = 1'b0; look_en = 1'b0;
    look("R4 next cycle", addr_of(0));

    // R3: every single-bit neighbour misses
    for (int b = 0; b < 32; b++) look("R3 bit flip", addr_of(0) ^ (32'h1 << b));
    look("R3 exact", addr_of(0));

    // R2: no strobe, no output
    @(negedge clk);
    look_en = 1'b0; look_addr = addr_of(0);
    #1 check("R2 idle", look_hit, look_line, 1'b0, '0, addr_of(0));

    // R8: flush with a concurrent fill
    fill(addr_of(1), 0, 1'b1);
    look("R8 flushed", addr_of(0));
    look("R8 fill dropped", addr_of(1));

    // R5/R6: 15 fills, refill first in place, then overflow
    for (int k = 0; k < 15; k++) begin
      fill(addr_of(k), 0, 1'b0);
      sweep("R5 allocate", 16);
    end
    fill(addr_of(0), 3, 1'b0);
    look("R6 rewrite data", addr_of(0));
    fill(addr_of(15), 0, 1'b0);
    sweep("R5 capacity", 16);
    fill(addr_of(16), 0, 1'b0);
    sweep("R6 no duplicate", 17);
    fill(addr_of(17), 0, 1'b0);
    sweep("R6 evict order", 17);

    // R7: continuing round-robin evictions with wrap
    for (int k = 18; k < 40; k++) begin
      fill(addr_of(k), k, 1'b0);
      sweep("R7 round robin", k);
    end

    // R8/R7: flush resets pointer
    fill(addr_of(50), 0, 1'b1);
    sweep("R8 after flush", 39);
    for (int k = 60; k < 78; k++) begin
      fill(addr_of(k), 1, 1'b0);
      for (int j = 60; j <= k; j++) look("R7 pointer reset", addr_of(j));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule